// File: doc/BRIEF.md
# Test Cell and PRBS Pattern Generator/Checker

This block is a built-in line test source and sink for a serial datapath, one bit per clock. In cell mode it sends fixed-size test cells. Each cell has a constant header followed by a payload taken from a 2^15-1 pseudo-random sequence. On the receive side it follows the same sequence through the payload of incoming cells. An upstream stage marks each cell boundary with a strobe. In clear-channel mode the sequence fills every transmitted bit, and the checker compares every received bit.

The checker seeds a local register from the received bits and then verifies a run of error-free bits before it declares lock. From then on it counts mismatched bits into a saturating counter that clears when read. Lock is dropped, and the search restarts, when errors come too densely. In cell mode the generator runs either continuously or as a burst of a fixed number of cells, started by a rising edge of the enable. A done flag reports when the burst has finished.

Top module: `tpat_unit`

## Requirements
- R1: With `cfg_clear_mode`=1 every transmitted bit is sequence data and `tx_cell_start` never pulses. With `cfg_clear_mode`=0 the stream is made of cells of HDR_BYTES*8 + PAY_BYTES*8 bits (40 + 384 by default). Each cell starts with HDR_PAT sent MSB first, and `tx_cell_start` is high on the first header bit.
- R2: While `cfg_enable` is 0, `tx_valid`, `tx_bit` and `sts_lock` are 0 and the checker is held in its search state.
- R3: The sequence register is 15 bits and is set to all ones on every enable rising edge. Each sequence bit is s[14]^s[13], and that bit is shifted in at bit 0. In cell mode the register advances only on payload bits, so the sequence continues from one cell to the next.
- R4: `tx_valid` rises in the cycle after the clock edge at which `cfg_enable` is first sampled high. In continuous cell mode (`cfg_burst`=0), cells follow back to back for as long as the enable stays high.
- R5: In cell mode with `cfg_burst`=1, each enable rising edge sends exactly BURST_CELLS cells. After that `tx_valid` stays low, even if the enable stays high.
- R6: `sts_done` goes to 0 at an enable rising edge. It goes to 1 in the cycle after the last bit of a completed burst, holds while the enable is low, and is never set by a continuous or clear-channel run.
- R7: In clear-channel mode `cfg_burst` has no effect, and the stream continues while the enable is high.
- R8: The checker takes 15 checked bits as its seed. It then needs LOCK_GOOD (32) consecutive matching bits to set `sts_lock`. In clear-channel mode, lock is visible 48 cycles after the enable is set on a clean loopback. In cell mode only payload bits are checked, with cell positions counted from `rx_cell_start`.
- R9: A mismatch during the run of matching bits sends the checker back to seeding, starting with the next checked bit. `sts_lock` stays 0.
- R10: Each mismatched bit while locked increments `err_count`. Mismatches before lock are not counted.
- R11: LOSS_ERRS (8) errors within LOSS_WIN (64) checked bits, counted from the first error, drop the lock and restart seeding. Seven errors in such a window keep the lock.
- R12: `err_count` saturates at 2^ERR_W-1. A one-cycle `err_rd` pulse makes it 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_clear_mode | input | 1 | 0 = cell mode, 1 = clear-channel mode |
| cfg_enable | input | 1 | Enables generator and checker; rising edge starts a run |
| cfg_burst | input | 1 | Cell mode only: 0 continuous, 1 burst of BURST_CELLS cells |
| err_rd | input | 1 | Read strobe that clears the error counter |
| tx_bit | output | 1 | Outbound serial bit |
| tx_valid | output | 1 | Outbound bit is generated data |
| tx_cell_start | output | 1 | First header bit of an outbound cell |
| rx_bit | input | 1 | Inbound serial bit |
| rx_valid | input | 1 | Inbound bit is present |
| rx_cell_start | input | 1 | Inbound bit is the first bit of a cell |
| sts_done | output | 1 | Most recent burst has completed |
| sts_lock | output | 1 | Checker has pattern lock |
| err_count | output | ERR_W | Saturating bit-error count, clears on read |

## Verification
The transmit stream is looped back to the receive side, and each mode is run through one vector table: clear-channel, continuous cells, a burst, and clear-channel with the burst select set. The counts of cell strobes and valid bits, and a bit-by-bit model of the sequence, separate cell framing from a raw stream and a burst from a continuous run. Single bit flips are then injected at chosen points. One flip during the search shows up as a lock delay. One flip after lock shows up in the counter. Seven and eight flips distinguish keeping the lock from losing it. Flips spaced ten bits apart drive the counter into saturation without losing lock.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
  localparam int unsigned PN_W = 15;

  typedef enum logic [1:0] {
    CK_SEED = 2'd0,
    CK_HUNT = 2'd1,
    CK_LOCK = 2'd2
  } ck_state_e;

  function automatic logic pn_fb(input logic [PN_W-1:0] s);
    return s[14] ^ s[13];
  endfunction
endpackage

// File: rtl/tpat_ctrl.sv
module tpat_ctrl #(
  parameter int unsigned BURST_CELLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clear_mode,
  input  logic burst_mode,
  input  logic cell_last,
  output logic start,
  output logic run,
  output logic done
);
  localparam int unsigned BC_W = $clog2(BURST_CELLS + 1);

  logic            en_q, run_q, run_d, bact_q, bact_d, done_q, done_d;
  logic [BC_W-1:0] bcnt_q, bcnt_d;
  logic            rise;

  assign rise = en & ~en_q;

  always_comb begin
    run_d  = run_q;
    bact_d = bact_q;
    bcnt_d = bcnt_q;
    done_d = done_q;
    if (!en) begin
      run_d  = 1'b0;
      bact_d = 1'b0;
    end else if (rise) begin
      run_d  = 1'b1;
      bact_d = ~clear_mode & burst_mode;
      bcnt_d = '0;
      done_d = 1'b0;
    end else if (run_q && bact_q && cell_last) begin
      if (bcnt_q == BC_W'(BURST_CELLS - 1)) begin
        run_d  = 1'b0;
        bact_d = 1'b0;
        done_d = 1'b1;
      end else begin
        bcnt_d = bcnt_q + BC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      bact_q <= 1'b0;
      bcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      en_q   <= en;
      run_q  <= run_d;
      bact_q <= bact_d;
      bcnt_q <= bcnt_d;
      done_q <= done_d;
    end
  end

  assign start = rise;
  assign run   = run_q;
  assign done  = done_q;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !run); // R2
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> !done); // R6
  AST_BURST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$rose(en)) |-> !run); // R5
endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
  import tpat_pkg::*;
#(
  parameter int unsigned HDR_BITS  = 40,
  parameter int unsigned CELL_BITS = 424,
  parameter logic [HDR_BITS-1:0] HDR_PAT = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic clear_mode,
  output logic tx_bit,
  output logic tx_valid,
  output logic tx_cell_start,
  output logic cell_last
);
  localparam int unsigned POS_W = $clog2(CELL_BITS);

  logic [POS_W-1:0]    pos_q, pos_d;
  logic [PN_W-1:0]     pn_q, pn_d;
  logic [HDR_BITS-1:0] hdr_sh;
  logic                in_hdr, fb, at_end;

  assign in_hdr = ~clear_mode & (pos_q < POS_W'(HDR_BITS));
  assign at_end = pos_q == POS_W'(CELL_BITS - 1);
  assign fb     = pn_fb(pn_q);
  assign hdr_sh = HDR_PAT << pos_q;

  always_comb begin
    pos_d = pos_q;
    pn_d  = pn_q;
    if (start) begin
      pos_d = '0;
      pn_d  = '1;
    end else if (run) begin
      if (!in_hdr) pn_d = {pn_q[PN_W-2:0], fb};
      if (clear_mode || at_end) pos_d = '0;
      else                      pos_d = pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      pn_q  <= '1;
    end else begin
      pos_q <= pos_d;
      pn_q  <= pn_d;
    end
  end

  assign tx_valid      = run;
  assign tx_bit        = run & (in_hdr ? hdr_sh[HDR_BITS-1] : fb);
  assign tx_cell_start = run & ~clear_mode & (pos_q == '0);
  assign cell_last     = run & ~clear_mode & at_end;

  AST_START_SEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pn_q == '1 && pos_q == '0)); // R3
  AST_CELL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cell_start |=> !tx_cell_start); // R1
endmodule

// File: rtl/tpat_chk.sv
module tpat_chk
  import tpat_pkg::*;
#(
  parameter int unsigned HDR_BITS  = 40,
  parameter int unsigned CELL_BITS = 424,
  parameter int unsigned LOCK_GOOD = 32,
  parameter int unsigned LOSS_ERRS = 8,
  parameter int unsigned LOSS_WIN  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clear_mode,
  input  logic rx_bit,
  input  logic rx_valid,
  input  logic rx_cell_start,
  output logic lock,
  output logic err_pulse
);
  localparam int unsigned RP_W  = $clog2(CELL_BITS + 1);
  localparam int unsigned CNT_W = $clog2((LOCK_GOOD > PN_W) ? LOCK_GOOD : PN_W);
  localparam int unsigned EC_W  = $clog2(LOSS_ERRS + 1);
  localparam int unsigned WC_W  = $clog2(LOSS_WIN);

  ck_state_e        st_q, st_d;
  logic [PN_W-1:0]  pn_q, pn_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EC_W-1:0]  ecnt_q, ecnt_d, ne;
  logic [WC_W-1:0]  wcnt_q, wcnt_d, nw;
  logic [RP_W-1:0]  rpos_q, rpos_d, cur;
  logic             use_bit, pred, mism;

  assign cur     = rx_cell_start ? '0 : rpos_q;
  assign use_bit = rx_valid & (clear_mode |
                   ((cur >= RP_W'(HDR_BITS)) & (cur < RP_W'(CELL_BITS))));
  assign pred    = pn_fb(pn_q);
  assign mism    = rx_bit ^ pred;
  assign ne      = ecnt_q + EC_W'(mism);
  assign nw      = wcnt_q + WC_W'(1);

  always_comb begin
    st_d      = st_q;
    pn_d      = pn_q;
    cnt_d     = cnt_q;
    ecnt_d    = ecnt_q;
    wcnt_d    = wcnt_q;
    rpos_d    = rpos_q;
    err_pulse = 1'b0;
    if (!en) begin
      st_d   = CK_SEED;
      cnt_d  = '0;
      ecnt_d = '0;
      wcnt_d = '0;
      rpos_d = RP_W'(CELL_BITS);
    end else begin
      if (rx_valid) rpos_d = (cur < RP_W'(CELL_BITS)) ? cur + RP_W'(1) : cur;
      if (use_bit) begin
        case (st_q)
          CK_SEED: begin
            pn_d = {pn_q[PN_W-2:0], rx_bit};
            if (cnt_q == CNT_W'(PN_W - 1)) begin
              st_d  = CK_HUNT;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
          CK_HUNT: begin
            pn_d = {pn_q[PN_W-2:0], pred};
            if (mism) begin
              st_d  = CK_SEED;
              cnt_d = '0;
            end else if (cnt_q == CNT_W'(LOCK_GOOD - 1)) begin
              st_d   = CK_LOCK;
              cnt_d  = '0;
              ecnt_d = '0;
              wcnt_d = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
          CK_LOCK: begin
            pn_d      = {pn_q[PN_W-2:0], pred};
            err_pulse = mism;
            if (ecnt_q == '0) begin
              if (mism) begin
                ecnt_d = EC_W'(1);
                wcnt_d = '0;
              end
            end else if (ne >= EC_W'(LOSS_ERRS)) begin
              st_d   = CK_SEED;
              cnt_d  = '0;
              ecnt_d = '0;
              wcnt_d = '0;
            end else if (nw == WC_W'(LOSS_WIN - 1)) begin
              ecnt_d = '0;
              wcnt_d = '0;
            end else begin
              ecnt_d = ne;
              wcnt_d = nw;
            end
          end
          default: st_d = CK_SEED;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CK_SEED;
      pn_q   <= '1;
      cnt_q  <= '0;
      ecnt_q <= '0;
      wcnt_q <= '0;
      rpos_q <= RP_W'(CELL_BITS);
    end else begin
      st_q   <= st_d;
      pn_q   <= pn_d;
      cnt_q  <= cnt_d;
      ecnt_q <= ecnt_d;
      wcnt_q <= wcnt_d;
      rpos_q <= rpos_d;
    end
  end

  assign lock = st_q == CK_LOCK;

  AST_LOCK_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !lock); // R2
  AST_LOCK_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(st_q == CK_HUNT)); // R8
  AST_HUNT_MISS_RESEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && use_bit && st_q == CK_HUNT && mism) |=> (st_q == CK_SEED)); // R9
endmodule

// File: rtl/tpat_errcnt.sv
module tpat_errcnt #(
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rd,
  output logic [ERR_W-1:0] count
);
  logic [ERR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (rd)                          cnt_d = '0;
    else if (inc && (cnt_q != '1))   cnt_d = cnt_q + ERR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !rd) |=> (cnt_q == '1)); // R12
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (cnt_q == '0)); // R12
endmodule

// File: rtl/tpat_unit.sv
module tpat_unit #(
  parameter int unsigned HDR_BYTES   = 5,
  parameter int unsigned PAY_BYTES   = 48,
  parameter int unsigned BURST_CELLS = 1024,
  parameter int unsigned ERR_W       = 16,
  parameter int unsigned LOCK_GOOD   = 32,
  parameter int unsigned LOSS_ERRS   = 8,
  parameter int unsigned LOSS_WIN    = 64,
  parameter logic [HDR_BYTES*8-1:0] HDR_PAT = 'h00_00_00_01_5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clear_mode,
  input  logic             cfg_enable,
  input  logic             cfg_burst,
  input  logic             err_rd,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             tx_cell_start,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             rx_cell_start,
  output logic             sts_done,
  output logic             sts_lock,
  output logic [ERR_W-1:0] err_count
);
  localparam int unsigned HDR_BITS  = HDR_BYTES * 8;
  localparam int unsigned CELL_BITS = (HDR_BYTES + PAY_BYTES) * 8;

  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       start, run, cell_last, err_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  tpat_ctrl #(.BURST_CELLS(BURST_CELLS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i),
    .en         (cfg_enable),
    .clear_mode (cfg_clear_mode),
    .burst_mode (cfg_burst),
    .cell_last  (cell_last),
    .start      (start),
    .run        (run),
    .done       (sts_done)
  );

  tpat_gen #(
    .HDR_BITS  (HDR_BITS),
    .CELL_BITS (CELL_BITS),
    .HDR_PAT   (HDR_PAT)
  ) u_gen (
    .clk           (clk),
    .rst_n         (rst_i),
    .start         (start),
    .run           (run),
    .clear_mode    (cfg_clear_mode),
    .tx_bit        (tx_bit),
    .tx_valid      (tx_valid),
    .tx_cell_start (tx_cell_start),
    .cell_last     (cell_last)
  );

  tpat_chk #(
    .HDR_BITS  (HDR_BITS),
    .CELL_BITS (CELL_BITS),
    .LOCK_GOOD (LOCK_GOOD),
    .LOSS_ERRS (LOSS_ERRS),
    .LOSS_WIN  (LOSS_WIN)
  ) u_chk (
    .clk           (clk),
    .rst_n         (rst_i),
    .en            (cfg_enable),
    .clear_mode    (cfg_clear_mode),
    .rx_bit        (rx_bit),
    .rx_valid      (rx_valid),
    .rx_cell_start (rx_cell_start),
    .lock          (sts_lock),
    .err_pulse     (err_pulse)
  );

  tpat_errcnt #(.ERR_W(ERR_W)) u_err (
    .clk   (clk),
    .rst_n (rst_i),
    .inc   (err_pulse),
    .rd    (err_rd),
    .count (err_count)
  );

  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_i)
    (err_count != $past(err_count) && err_count != '0) |-> $past(sts_lock)); // R10
endmodule

// File: tb/tb_tpat_unit.sv
module tb_tpat_unit;
  localparam int unsigned NCELLS = 3;
  localparam int unsigned EW     = 8;
  localparam int unsigned HB     = 40;
  localparam int unsigned CB     = 424;
  localparam logic [39:0] HDR    = 40'hC3_00_00_01_9E;

  typedef struct packed {
    logic        clr;
    logic        bur;
    logic [15:0] run;
    logic [15:0] starts;
    logic [15:0] valids;
    logic        done;
    logic        lock;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b0, 16'd600,  16'd0, 16'd600,  1'b0, 1'b1},
    '{1'b0, 1'b0, 16'd2000, 16'd5, 16'd2000, 1'b0, 1'b1},
    '{1'b0, 1'b1, 16'd2000, 16'd3, 16'd1272, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'd2000, 16'd0, 16'd2000, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, clr, en, bur, rd, flip;
  logic tx_bit, tx_valid, tx_cs, done, lock;
  logic [EW-1:0] errc;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tpat_unit #(
    .BURST_CELLS (NCELLS),
    .ERR_W       (EW),
    .HDR_PAT     (HDR)
  ) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_clear_mode (clr),
    .cfg_enable     (en),
    .cfg_burst      (bur),
    .err_rd         (rd),
    .tx_bit         (tx_bit),
    .tx_valid       (tx_valid),
    .tx_cell_start  (tx_cs),
    .rx_bit         (tx_bit ^ flip),
    .rx_valid       (tx_valid),
    .rx_cell_start  (tx_cs),
    .sts_done       (done),
    .sts_lock       (lock),
    .err_count      (errc)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic start_run(input logic c, input logic b);
    en = 1'b0; clr = c; bur = b;
    repeat (4) tick();
    en = 1'b1;
  endtask

  task automatic inject(input int n);
    for (int i = 0; i < n; i++) begin
      flip = 1'b1;
      tick();
    end
    flip = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; en = 1'b0; bur = 1'b0; rd = 1'b0; flip = 1'b0;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check("R2 reset tx_valid", tx_valid, 0);
    check("R2 reset lock", lock, 0);
    check("R6 reset done", done, 0);
    check("R12 reset err_count", errc, 0);

    for (int v = 0; v < 4; v++) begin
      automatic int starts = 0, valids = 0, bad = 0, mpos = 0;
      automatic logic [14:0] m = '1;
      automatic logic e;
      en = 1'b0; clr = VECS[v].clr; bur = VECS[v].bur;
      repeat (4) tick();
      check("R2 idle tx_valid", tx_valid, 0);
      check("R2 idle tx_bit", tx_bit, 0);
      check("R2 idle lock", lock, 0);
      en = 1'b1;
      for (int c = 0; c < int'(VECS[v].run); c++) begin
        tick();
        if (tx_valid) begin
          valids++;
          if (tx_cs) starts++;
          if (VECS[v].clr || mpos >= HB) begin
            e = m[14] ^ m[13];
            m = {m[13:0], e};
          end else begin
            e = HDR[HB-1-mpos];
          end
          if (!VECS[v].clr) mpos = (mpos + 1) % CB;
          if (tx_bit !== e) bad++;
        end
      end
      check("R1 cell starts", starts, VECS[v].starts);
      check("R4 R5 R7 valid bits", valids, VECS[v].valids);
      check("R3 sequence and header bits", bad, 0);
      check("R6 done", done, VECS[v].done);
      check("R8 lock", lock, VECS[v].lock);
      check("R10 no errors on clean link", errc, 0);
    end

    // R6: done holds after a burst, then clears on the next rising edge
    start_run(1'b0, 1'b1);
    repeat (1300) tick();
    check("R6 done after burst", done, 1);
    check("R5 stopped with enable high", tx_valid, 0);
    en = 1'b0;
    repeat (3) tick();
    check("R6 done held while off", done, 1);
    en = 1'b1;
    tick();
    check("R6 done cleared by rise", done, 0);

    // R8: exact lock cycle in clear-channel mode
    start_run(1'b1, 1'b0);
    repeat (47) tick();
    check("R8 not locked yet", lock, 0);
    tick();
    check("R8 locked", lock, 1);

    // R9: a flip during the search delays lock
    start_run(1'b1, 1'b0);
    repeat (20) tick();
    inject(1);
    repeat (46) tick();
    check("R9 still searching", lock, 0);
    tick();
    check("R9 locked after reseed", lock, 1);
    check("R10 search errors not counted", errc, 0);

    // R10: one flip after lock
    repeat (20) tick();
    inject(1);
    check("R10 single error counted", errc, 1);
    repeat (100) tick();

    // R11: seven errors keep lock, eight drop it
    inject(7);
    check("R11 seven errors counted", errc, 8);
    check("R11 lock kept", lock, 1);
    repeat (100) tick();
    inject(8);
    check("R11 lock dropped", lock, 0);
    check("R10 eight errors counted", errc, 16);
    repeat (60) tick();
    check("R11 relocked", lock, 1);

    // R12: read clears
    rd = 1'b1;
    tick();
    rd = 1'b0;
    check("R12 read clears", errc, 0);

    // R12: saturation with spaced errors
    for (int i = 0; i < 300; i++) begin
      inject(1);
      repeat (9) tick();
    end
    check("R12 saturated", errc, 255);
    check("R11 lock kept under spaced errors", lock, 1);
    rd = 1'b1;
    tick();
    rd = 1'b0;
    check("R12 read clears from max", errc, 0);

    en = 1'b0;
    repeat (2) tick();
    check("R2 lock off after disable", lock, 0);
    summary();
  end
endmodule